// File: doc/BRIEF.md
# Speculative Load Queue with Coherence Replay

This block tracks loads in an out-of-order core so that the machine can reorder them freely and still behave as if every memory access took place in program order. Each load takes a slot in a circular queue at dispatch, in program order. When it executes, the slot records the cache-line address it read. From then until it retires, the load is exposed to coherence traffic: any bus write or bus upgrade that another processor sends for that line sets a replay mark on the slot.

Retirement is in order and is requested one load at a time. An executed, unmarked head load retires. A marked head load does not retire. Instead the queue reports a replay from that slot, drops the slot and every younger slot, and rewinds its tail to the head so the pipeline can refetch from the offending load. Conflicts are expected to be rare, so a full flush on a hit costs little on average. A separate flush input lets the rest of the pipeline squash a load and everything younger, for example after a branch mispredict.

Top module: `spec_load_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `commit_done_o` and `replay_o` are 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx_o`, which then advances by one modulo DEPTH. When DEPTH loads are held, `alloc_ready_o` is 0 and an allocation request is refused without moving the tail.
- R3: An execute report for a slot that holds no load is ignored. If that slot is allocated later, it starts out unexecuted.
- R4: A commit request retires the head only if the head holds an executed, unmarked load. In that case `commit_done_o` is 1 in the following cycle and the slot is freed. On an empty queue or an unexecuted head, a commit request has no effect.
- R5: A commit request on a marked head gives `replay_o`=1, with `replay_idx_o` equal to the head slot, in the following cycle, and no commit. Every held load is dropped and the tail returns to the head, so `alloc_idx_o` equals `replay_idx_o` afterwards.
- R6: A snoop never marks a load that has not yet executed. If that load executes after the snoop, it later retires normally.
- R7: A snoop that matches the line of a load executing in the same cycle marks that load.
- R8: A snoop that matches the head's line in the same cycle as a commit request on that head causes a replay, not a commit.
- R9: `flush_i`, when `flush_idx_i` names a held slot, drops that slot and all younger ones and moves the tail to `flush_idx_i`. Older loads are kept. In a cycle where `flush_i` is high, commit requests and allocations are ignored.
- R10: Addresses are compared by cache line: the low LINE_OFF bits (6 by default) are ignored, and any difference in the higher bits means no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid_i | input | 1 | Request to allocate a slot for the next load in program order |
| alloc_ready_o | output | 1 | A slot can be taken in this cycle |
| alloc_idx_o | output | IDX_W | Slot that the next allocation will take (tail) |
| exec_valid_i | input | 1 | A load has executed |
| exec_idx_i | input | IDX_W | Slot of the executed load |
| exec_addr_i | input | ADDR_W | Address read by the executed load |
| snoop_valid_i | input | 1 | A remote bus write or upgrade is observed |
| snoop_addr_i | input | ADDR_W | Address of the snooped write or upgrade |
| commit_req_i | input | 1 | Request to retire the head load |
| commit_done_o | output | 1 | The head load retired in the previous cycle |
| replay_o | output | 1 | Replay required: pipeline flush from `replay_idx_o` |
| replay_idx_o | output | IDX_W | Slot of the load to refetch from |
| flush_i | input | 1 | Squash from `flush_idx_i` to the tail |
| flush_idx_i | input | IDX_W | Oldest slot to squash |

## Verification
Two pairs of events can land in the same cycle. A snoop can arrive together with the execute report for the same line, and a snoop can arrive together with a commit request on the head it hits. The bench drives both snoop and the other input in one cycle. For the first pair it then checks that a later commit request replays. For the second it checks that `replay_o` rises and `commit_done_o` stays low. The checker also requires that the marked state never exists without the executed state, and that a snoop hit on a slot that is not being cleared always leaves that slot marked.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Outcome of the head-of-queue commit decision in one cycle.
  typedef enum logic [1:0] {
    HEAD_HOLD   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_REPLAY = 2'd2
  } head_act_e;
endpackage

// File: rtl/lq_slot.sv
module lq_slot #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic              exec_i,
  input  logic [LINE_W-1:0] exec_line_i,
  input  logic              snoop_valid_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic              exec_o,
  output logic              mark_o,
  output logic              hit_o
);
  logic              valid_q, exec_q, mark_q;
  logic [LINE_W-1:0] line_q;
  logic              exec_take;
  logic              exec_race;

  // Snoop hit against a line already recorded by an executed load.
  assign hit_o     = snoop_valid_i && valid_q && exec_q && (line_q == snoop_line_i);
  assign exec_take = exec_i && valid_q;
  // Snoop for the line being recorded in this very cycle.
  assign exec_race = exec_take && snoop_valid_i && (snoop_line_i == exec_line_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      exec_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      exec_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      exec_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      if (exec_take) exec_q <= 1'b1;
      mark_q <= mark_q | hit_o | exec_race;
    end
  end

  // Address storage has no reset; it is qualified by exec_q.
  always_ff @(posedge clk) begin
    if (exec_take) line_q <= exec_line_i;
  end

  assign valid_o = valid_q;
  assign exec_o  = exec_q;
  assign mark_o  = mark_q;
endmodule

// File: rtl/lq_ptrs.sv
module lq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             cut_i,
  input  logic [IDX_W-1:0] cut_idx_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] keep;

  assign keep = cut_idx_i - head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (cut_i) begin
      tail_q  <= cut_idx_i;
      count_q <= CNT_W'(keep);
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lq_commit_ctrl.sv
module lq_commit_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_req_i,
  input  logic             block_i,
  input  logic             head_valid_i,
  input  logic             head_exec_i,
  input  logic             head_mark_i,
  input  logic             head_hit_i,
  input  logic [IDX_W-1:0] head_idx_i,
  output lq_pkg::head_act_e act_o,
  output logic             commit_done_o,
  output logic             replay_o,
  output logic [IDX_W-1:0] replay_idx_o
);
  import lq_pkg::*;
  logic ready_head;

  assign ready_head = commit_req_i && !block_i && head_valid_i && head_exec_i;

  always_comb begin
    act_o = HEAD_HOLD;
    if (ready_head) act_o = (head_mark_i || head_hit_i) ? HEAD_REPLAY : HEAD_RETIRE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_done_o <= 1'b0;
      replay_o      <= 1'b0;
      replay_idx_o  <= '0;
    end else begin
      commit_done_o <= (act_o == HEAD_RETIRE);
      replay_o      <= (act_o == HEAD_REPLAY);
      if (act_o == HEAD_REPLAY) replay_idx_o <= head_idx_i;
    end
  end
endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              exec_valid_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              commit_req_i,
  output logic              commit_done_o,
  output logic              replay_o,
  output logic [IDX_W-1:0]  replay_idx_o,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_idx_i
);
  import lq_pkg::*;

  logic [DEPTH-1:0] slot_valid, slot_exec, slot_mark, slot_hit, slot_clear;
  logic [IDX_W-1:0] head, tail;
  logic             full;
  logic             push, ext_cut, cut;
  logic [IDX_W-1:0] cut_idx, flush_dist;
  logic [LINE_W-1:0] exec_line, snoop_line;
  head_act_e        act;
  logic             replay_now, retire_now;

  assign exec_line  = exec_addr_i[ADDR_W-1:LINE_OFF];
  assign snoop_line = snoop_addr_i[ADDR_W-1:LINE_OFF];

  lq_commit_ctrl #(.DEPTH(DEPTH)) u_commit (
    .clk          (clk),
    .rst          (rst),
    .commit_req_i (commit_req_i),
    .block_i      (flush_i),
    .head_valid_i (slot_valid[head]),
    .head_exec_i  (slot_exec[head]),
    .head_mark_i  (slot_mark[head]),
    .head_hit_i   (slot_hit[head]),
    .head_idx_i   (head),
    .act_o        (act),
    .commit_done_o(commit_done_o),
    .replay_o     (replay_o),
    .replay_idx_o (replay_idx_o)
  );

  assign replay_now = (act == HEAD_REPLAY);
  assign retire_now = (act == HEAD_RETIRE);

  assign alloc_ready_o = !full && !flush_i && !replay_now;
  assign push          = alloc_valid_i && alloc_ready_o;
  assign ext_cut       = flush_i && slot_valid[flush_idx_i];
  assign cut           = replay_now || ext_cut;
  assign cut_idx       = replay_now ? head : flush_idx_i;
  assign flush_dist    = flush_idx_i - head;
  assign alloc_idx_o   = tail;

  lq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push),
    .pop_i    (retire_now),
    .cut_i    (cut),
    .cut_idx_i(cut_idx),
    .head_o   (head),
    .tail_o   (tail),
    .full_o   (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [IDX_W-1:0] age;
    assign age = IDX_W'(g) - head;
    assign slot_clear[g] = replay_now
                         || (ext_cut && slot_valid[g] && (age >= flush_dist))
                         || (retire_now && (head == IDX_W'(g)));

    lq_slot #(.LINE_W(LINE_W)) u_slot (
      .clk          (clk),
      .rst          (rst),
      .alloc_i      (push && (tail == IDX_W'(g))),
      .exec_i       (exec_valid_i && (exec_idx_i == IDX_W'(g))),
      .exec_line_i  (exec_line),
      .snoop_valid_i(snoop_valid_i),
      .snoop_line_i (snoop_line),
      .clear_i      (slot_clear[g]),
      .valid_o      (slot_valid[g]),
      .exec_o       (slot_exec[g]),
      .mark_o       (slot_mark[g]),
      .hit_o        (slot_hit[g])
    );
  end
endmodule

// File: rtl/spec_load_queue_chk.sv
module spec_load_queue_chk #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             commit_req_i,
  input logic             commit_done_o,
  input logic             replay_o,
  input logic             flush_i,
  input logic             alloc_ready_o,
  input logic [DEPTH-1:0] slot_exec,
  input logic [DEPTH-1:0] slot_mark,
  input logic [DEPTH-1:0] slot_hit,
  input logic [DEPTH-1:0] slot_clear
);
  AST_RETIRE_OR_REPLAY: assert property (@(posedge clk) disable iff (rst) !(commit_done_o && replay_o)); // R5
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) commit_done_o |-> $past(commit_req_i)); // R4
  AST_REPLAY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) replay_o |-> $past(commit_req_i)); // R5
  AST_REPLAY_FREES_ALL: assert property (@(posedge clk) disable iff (rst) (replay_o && !flush_i) |-> alloc_ready_o); // R5

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_MARK_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst) slot_mark[g] |-> slot_exec[g]); // R6
    AST_HIT_SETS_MARK: assert property (@(posedge clk) disable iff (rst) (slot_hit[g] && !slot_clear[g]) |=> slot_mark[g]); // R10
  end
endmodule

bind spec_load_queue spec_load_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .commit_req_i (commit_req_i),
  .commit_done_o(commit_done_o),
  .replay_o     (replay_o),
  .flush_i      (flush_i),
  .alloc_ready_o(alloc_ready_o),
  .slot_exec    (slot_exec),
  .slot_mark    (slot_mark),
  .slot_hit     (slot_hit),
  .slot_clear   (slot_clear)
);

// File: tb/spec_load_queue_tb_top.sv
module spec_load_queue_tb_top;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid_i = 1'b0;
  logic alloc_ready_o;
  logic [IDX_W-1:0] alloc_idx_o;
  logic exec_valid_i = 1'b0;
  logic [IDX_W-1:0] exec_idx_i = '0;
  logic [ADDR_W-1:0] exec_addr_i = '0;
  logic snoop_valid_i = 1'b0;
  logic [ADDR_W-1:0] snoop_addr_i = '0;
  logic commit_req_i = 1'b0;
  logic commit_done_o, replay_o;
  logic [IDX_W-1:0] replay_idx_o;
  logic flush_i = 1'b0;
  logic [IDX_W-1:0] flush_idx_i = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic alloc_n(input int n);
    for (int i = 0; i < n; i++) begin
      alloc_valid_i = 1'b1;
      tick();
      alloc_valid_i = 1'b0;
    end
  endtask

  task automatic exec_one(input int idx, input logic [ADDR_W-1:0] a, input logic snp);
    exec_valid_i = 1'b1; exec_idx_i = IDX_W'(idx); exec_addr_i = a;
    snoop_valid_i = snp; snoop_addr_i = a;
    tick();
    exec_valid_i = 1'b0; snoop_valid_i = 1'b0;
  endtask

  task automatic snoop_one(input logic [ADDR_W-1:0] a);
    snoop_valid_i = 1'b1; snoop_addr_i = a;
    tick();
    snoop_valid_i = 1'b0;
  endtask

  task automatic commit_one();
    commit_req_i = 1'b1;
    tick();
    commit_req_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready", alloc_ready_o, 1);
    chk("R1 idx", alloc_idx_o, 0);
    chk("R1 done", commit_done_o, 0);
    chk("R1 replay", replay_o, 0);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 idx", alloc_idx_o, i);
      alloc_n(1);
    end
    chk("R2 full ready", alloc_ready_o, 0);
    alloc_n(1);
    chk("R2 refused tail", alloc_idx_o, 0);
    exec_one(0, 32'h1000, 1'b0);
    commit_one();
    chk("R4 retire", commit_done_o, 1);
    chk("R2 ready after retire", alloc_ready_o, 1);
  endtask

  task automatic t_unalloc_exec();
    do_reset();
    exec_one(0, 32'h2000, 1'b0);
    alloc_n(1);
    commit_one();
    chk("R3 stale exec", commit_done_o, 0);
    commit_one();
    chk("R4 unexec head", commit_done_o, 0);
    exec_one(0, 32'h2000, 1'b0);
    commit_one();
    chk("R4 retire", commit_done_o, 1);
    commit_one();
    chk("R4 empty", commit_done_o, 0);
  endtask

  task automatic t_snoop_replay();
    do_reset();
    alloc_n(3);
    exec_one(0, 32'h4000, 1'b0);
    exec_one(1, 32'h5000, 1'b0);
    snoop_one(32'h5025);
    commit_one();
    chk("R10 other line", commit_done_o, 1);
    commit_one();
    chk("R5 replay", replay_o, 1);
    chk("R5 no commit", commit_done_o, 0);
    chk("R5 replay idx", replay_idx_o, 1);
    chk("R5 tail rewind", alloc_idx_o, 1);
    exec_one(2, 32'h6000, 1'b0);
    commit_one();
    chk("R5 younger dropped", commit_done_o, 0);
  endtask

  task automatic t_line_miss();
    do_reset();
    alloc_n(1);
    exec_one(0, 32'h8000, 1'b0);
    snoop_one(32'h8040);
    commit_one();
    chk("R10 next line", commit_done_o, 1);
    chk("R10 no replay", replay_o, 0);
  endtask

  task automatic t_unexec_snoop();
    do_reset();
    alloc_n(1);
    snoop_one(32'h9000);
    exec_one(0, 32'h9000, 1'b0);
    commit_one();
    chk("R6 retire", commit_done_o, 1);
  endtask

  task automatic t_exec_race();
    do_reset();
    alloc_n(1);
    exec_one(0, 32'hA010, 1'b1);
    commit_one();
    chk("R7 replay", replay_o, 1);
  endtask

  task automatic t_commit_race();
    do_reset();
    alloc_n(1);
    exec_one(0, 32'hB000, 1'b0);
    commit_req_i = 1'b1; snoop_valid_i = 1'b1; snoop_addr_i = 32'hB03F;
    tick();
    commit_req_i = 1'b0; snoop_valid_i = 1'b0;
    chk("R8 replay", replay_o, 1);
    chk("R8 no commit", commit_done_o, 0);
  endtask

  task automatic t_flush();
    do_reset();
    alloc_n(4);
    for (int i = 0; i < 4; i++) exec_one(i, 32'hC000 + 32'(i * 64), 1'b0);
    flush_i = 1'b1; flush_idx_i = 2; commit_req_i = 1'b1;
    tick();
    flush_i = 1'b0; commit_req_i = 1'b0;
    chk("R9 tail", alloc_idx_o, 2);
    chk("R9 commit blocked", commit_done_o, 0);
    commit_one();
    chk("R9 keep 0", commit_done_o, 1);
    commit_one();
    chk("R9 keep 1", commit_done_o, 1);
    commit_one();
    chk("R9 dropped 2", commit_done_o, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_unalloc_exec();
    t_snoop_replay();
    t_line_miss();
    t_unexec_snoop();
    t_exec_race();
    t_commit_race();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule